// File: doc/BRIEF.md
# Predicate test flag generator

This unit evaluates a source predicate under a governing mask and produces the four condition flags N, Z, C and V. Both predicates hold one bit per byte element of a vector whose width in bits is a parameter. Only elements whose mask bit is set take part. N reports the source value at the lowest active element. C reports the inverse of the source value at the highest active element. Z reports that no active element is true. V is always cleared.

The unit contains a small predicate register file with one write port. It decodes a 32-bit instruction word to pick the mask register and the source register. When a matching instruction is issued with the unit enabled, the flags are registered on the next clock edge and a one-cycle valid pulse accompanies the update. An instruction that does not match, or any instruction issued while the unit is disabled, leaves the flags as they were and pulses an undefined-instruction output.

Top module: `pred_flag_unit`

## Requirements
- R1: The vector width VEC_BITS is a multiple of 128 in the range 128 to 2048. Each predicate has VEC_BITS/8 bits, where bit i belongs to byte element i.
- R2: An instruction word matches when (word & 32'hFFFFC21F) == 32'h2550C000. Bits 13:10 give the mask register index and bits 8:5 give the source register index.
- R3: Z is 1 exactly when no element has both its mask bit and its source bit set.
- R4: N equals the source bit at the lowest-indexed element whose mask bit is 1. N is 0 when the mask is all zero.
- R5: C equals the inverse of the source bit at the highest-indexed element whose mask bit is 1. C is 1 when the mask is all zero.
- R6: V is 0 after every update and out of reset.
- R7: A matching instruction sampled with instr_valid_i=1 and en_i=1 at a rising edge sets the flags at that edge. flags_valid_o is 1 for exactly the following cycle.
- R8: An instruction sampled with instr_valid_i=1 that does not match, or that arrives with en_i=0, leaves all flags unchanged. It pulses undef_o for one cycle and keeps flags_valid_o at 0.
- R9: During reset the outputs are N=Z=C=V=0, flags_valid_o=0 and undef_o=0, and every predicate register is cleared.
- R10: A register write at a rising edge is seen by an instruction sampled at any later edge. Source bits of elements whose mask bit is 0 have no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Unit enable; instructions issued while it is low are treated as undefined |
| preg_we_i | input | 1 | Predicate register write strobe |
| preg_widx_i | input | 4 | Index of the register to write |
| preg_wdata_i | input | VEC_BITS/8 | Predicate value to write |
| instr_valid_i | input | 1 | Instruction strobe |
| instr_i | input | 32 | Instruction word |
| flag_n_o | output | 1 | Source bit at the first active element |
| flag_z_o | output | 1 | No active element is true |
| flag_c_o | output | 1 | Inverse of the source bit at the last active element |
| flag_v_o | output | 1 | Always 0 |
| flags_valid_o | output | 1 | One-cycle pulse when the flags update |
| undef_o | output | 1 | One-cycle pulse for an unmatched or disabled instruction |

## Verification
The assertions check on every cycle the relations that any correct result must satisfy:
- Z and N are never both set.
- Z implies C.
- Every enabled, matching strobe is followed by a valid pulse.
- Every other strobe is followed by an undefined pulse.
- The flags never change without a valid pulse.

Only the bench's scenarios can show that N and C come from the correct edge elements. The bench compares against a reference model over tabled and random masks. Those scenarios also cover an all-zero mask, a single active element, masked-out source bits, the decoding of register indices and the write-then-read ordering of the register file.

// File: rtl/pfu_pkg.sv
package pfu_pkg;
  localparam logic [31:0] PTEST_FIXED = 32'h2550C000;
  localparam logic [31:0] PTEST_CARE  = 32'hFFFFC21F;
  localparam int unsigned PIDX_W      = 4;
  localparam int unsigned NUM_PREGS   = 1 << PIDX_W;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;
endpackage

// File: rtl/pfu_decode.sv
module pfu_decode
  import pfu_pkg::*;
(
  input  logic [31:0]       instr_i,
  output logic              match_o,
  output logic [PIDX_W-1:0] pg_idx_o,
  output logic [PIDX_W-1:0] pn_idx_o
);
  assign match_o  = (instr_i & PTEST_CARE) == PTEST_FIXED;
  assign pg_idx_o = instr_i[13:10];
  assign pn_idx_o = instr_i[8:5];
endmodule

// File: rtl/pfu_preg_file.sv
module pfu_preg_file
  import pfu_pkg::*;
#(
  parameter int unsigned PL = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PIDX_W-1:0] widx_i,
  input  logic [PL-1:0]     wdata_i,
  input  logic [PIDX_W-1:0] ra_idx_i,
  input  logic [PIDX_W-1:0] rb_idx_i,
  output logic [PL-1:0]     ra_o,
  output logic [PL-1:0]     rb_o
);
  logic [PL-1:0] regs_q [NUM_PREGS];

  for (genvar g = 0; g < NUM_PREGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 regs_q[g] <= '0;
      else if (we_i && widx_i == PIDX_W'(g))       regs_q[g] <= wdata_i;
    end
  end

  assign ra_o = regs_q[ra_idx_i];
  assign rb_o = regs_q[rb_idx_i];
endmodule

// File: rtl/pfu_edge_pick.sv
// One-hot of the lowest (FROM_TOP=0) or highest (FROM_TOP=1) set bit.
module pfu_edge_pick #(
  parameter int unsigned W        = 32,
  parameter bit          FROM_TOP = 1'b0
) (
  input  logic [W-1:0] act_i,
  output logic [W-1:0] sel_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  if (FROM_TOP) begin : g_top
    logic [W-1:0] rev, pick;
    for (genvar i = 0; i < W; i++) begin : g_rev
      assign rev[i]          = act_i[W-1-i];
      assign sel_o[W-1-i]    = pick[i];
    end
    assign pick = rev & (~rev + ONE);
  end else begin : g_bot
    assign sel_o = act_i & (~act_i + ONE);
  end
endmodule

// File: rtl/pred_flag_unit.sv
module pred_flag_unit
  import pfu_pkg::*;
#(
  parameter int unsigned VEC_BITS = 256,
  localparam int unsigned PL      = VEC_BITS / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              preg_we_i,
  input  logic [PIDX_W-1:0] preg_widx_i,
  input  logic [PL-1:0]     preg_wdata_i,
  input  logic              instr_valid_i,
  input  logic [31:0]       instr_i,
  output logic              flag_n_o,
  output logic              flag_z_o,
  output logic              flag_c_o,
  output logic              flag_v_o,
  output logic              flags_valid_o,
  output logic              undef_o
);
  logic              dec_match;
  logic [PIDX_W-1:0] pg_idx, pn_idx;
  logic [PL-1:0]     mask, src, first_sel, last_sel;
  nzcv_t             flags_d, flags_q;
  logic              exec;

  pfu_decode u_dec (
    .instr_i (instr_i),
    .match_o (dec_match),
    .pg_idx_o(pg_idx),
    .pn_idx_o(pn_idx)
  );

  pfu_preg_file #(.PL(PL)) u_prf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (preg_we_i),
    .widx_i  (preg_widx_i),
    .wdata_i (preg_wdata_i),
    .ra_idx_i(pg_idx),
    .rb_idx_i(pn_idx),
    .ra_o    (mask),
    .rb_o    (src)
  );

  pfu_edge_pick #(.W(PL), .FROM_TOP(1'b0)) u_first (.act_i(mask), .sel_o(first_sel));
  pfu_edge_pick #(.W(PL), .FROM_TOP(1'b1)) u_last  (.act_i(mask), .sel_o(last_sel));

  // empty mask: both selects are zero -> N=0, C=1
  always_comb begin
    flags_d.n = |(first_sel & src);
    flags_d.z = ~|(mask & src);
    flags_d.c = ~|(last_sel & src);
    flags_d.v = 1'b0;
  end

  assign exec = instr_valid_i && en_i && dec_match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q       <= '0;
      flags_valid_o <= 1'b0;
      undef_o       <= 1'b0;
    end else begin
      if (exec) flags_q <= flags_d;
      flags_valid_o <= exec;
      undef_o       <= instr_valid_i && !exec;
    end
  end

  assign flag_n_o = flags_q.n;
  assign flag_z_o = flags_q.z;
  assign flag_c_o = flags_q.c;
  assign flag_v_o = flags_q.v;
endmodule

// File: rtl/pred_flag_unit_chk.sv
module pred_flag_unit_chk #(
  parameter int unsigned VEC_BITS = 256
) (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic instr_valid_i,
  input logic dec_match,
  input logic flag_n_o,
  input logic flag_z_o,
  input logic flag_c_o,
  input logic flag_v_o,
  input logic flags_valid_o,
  input logic undef_o
);
  initial begin
    p_vec_len_r1: assert (VEC_BITS % 128 == 0 && VEC_BITS >= 128 && VEC_BITS <= 2048)
      else $error("VEC_BITS out of range");
  end

  p_empty_flags_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_valid_o && flag_z_o |-> !flag_n_o && flag_c_o);

  p_first_true_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_valid_o && flag_n_o |-> !flag_z_o);

  p_update_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && en_i && dec_match |=> flags_valid_o && !undef_o);

  p_reject_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && !(en_i && dec_match) |=> undef_o && !flags_valid_o);

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flags_valid_o |-> $stable({flag_n_o, flag_z_o, flag_c_o, flag_v_o}));
endmodule

bind pred_flag_unit pred_flag_unit_chk #(.VEC_BITS(VEC_BITS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .instr_valid_i(instr_valid_i),
  .dec_match    (dec_match),
  .flag_n_o     (flag_n_o),
  .flag_z_o     (flag_z_o),
  .flag_c_o     (flag_c_o),
  .flag_v_o     (flag_v_o),
  .flags_valid_o(flags_valid_o),
  .undef_o      (undef_o)
);

// File: tb/pred_flag_unit_tb.sv
module pred_flag_unit_tb;
  localparam int unsigned VB = 256;
  localparam int unsigned PL = VB / 8;
  localparam logic [31:0] BASE = 32'h2550C000;

  typedef struct packed {
    logic [31:0] m;
    logic [31:0] s;
    logic [2:0]  nzc;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t TBL [NV] = '{
    '{32'h00000000, 32'hFFFFFFFF, 3'b011},
    '{32'hFFFFFFFF, 32'h00000000, 3'b011},
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 3'b100},
    '{32'h00000010, 32'h00000010, 3'b100},
    '{32'h00000010, 32'hFFFFFFEF, 3'b011},
    '{32'h80000001, 32'h00000001, 3'b101},
    '{32'h80000001, 32'h80000000, 3'b000},
    '{32'h0000FF00, 32'h00010080, 3'b011},
    '{32'h0F0F0F00, 32'h08000100, 3'b100}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b1;
  logic preg_we_i = 1'b0;
  logic [3:0] preg_widx_i = '0;
  logic [PL-1:0] preg_wdata_i = '0;
  logic instr_valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic flag_n_o, flag_z_o, flag_c_o, flag_v_o, flags_valid_o, undef_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pred_flag_unit #(.VEC_BITS(VB)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i),
    .preg_we_i(preg_we_i), .preg_widx_i(preg_widx_i), .preg_wdata_i(preg_wdata_i),
    .instr_valid_i(instr_valid_i), .instr_i(instr_i),
    .flag_n_o(flag_n_o), .flag_z_o(flag_z_o), .flag_c_o(flag_c_o), .flag_v_o(flag_v_o),
    .flags_valid_o(flags_valid_o), .undef_o(undef_o)
  );

  function automatic logic [2:0] ref_nzc(input logic [PL-1:0] m, input logic [PL-1:0] s);
    logic n = 1'b0, any = 1'b0, lastv = 1'b0, seen = 1'b0;
    for (int i = 0; i < PL; i++) begin
      if (m[i]) begin
        if (!seen) n = s[i];
        seen  = 1'b1;
        lastv = s[i];
        if (s[i]) any = 1'b1;
      end
    end
    return {n, ~any, ~lastv};
  endfunction

  function automatic logic [31:0] mk_instr(input logic [3:0] pg, input logic [3:0] pn);
    return BASE | (32'(pg) << 10) | (32'(pn) << 5);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_preg(input logic [3:0] idx, input logic [PL-1:0] d);
    @(negedge clk);
    preg_we_i = 1'b1; preg_widx_i = idx; preg_wdata_i = d;
    @(negedge clk);
    preg_we_i = 1'b0;
  endtask

  // issue one instruction; returns sampled at the negedge after the update edge
  task automatic issue(input logic [31:0] w);
    @(negedge clk);
    instr_valid_i = 1'b1; instr_i = w;
    @(negedge clk);
    instr_valid_i = 1'b0;
  endtask

  task automatic run_case(input string req, input logic [3:0] pg, input logic [3:0] pn,
                          input logic [PL-1:0] m, input logic [PL-1:0] s);
    logic [2:0] e;
    wr_preg(pg, m);
    if (pn != pg) wr_preg(pn, s);
    e = (pn == pg) ? ref_nzc(m, m) : ref_nzc(m, s);
    issue(mk_instr(pg, pn));
    check({req, " R7 valid"}, {31'b0, flags_valid_o}, 32'd1);
    check({req, " R3/R4/R5 nzc"}, {29'b0, flag_n_o, flag_z_o, flag_c_o}, {29'b0, e});
    check({req, " R6 v"}, {31'b0, flag_v_o}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] snap;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 outputs in reset",
          {26'b0, flag_n_o, flag_z_o, flag_c_o, flag_v_o, flags_valid_o, undef_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    // R9: registers cleared -> empty mask result
    issue(mk_instr(4'd3, 4'd7));
    check("R9 cleared regs", {29'b0, flag_n_o, flag_z_o, flag_c_o}, 32'b011);

    // R10: vector table, masked-out bits ignored
    for (int i = 0; i < NV; i++) begin
      wr_preg(4'd1, TBL[i].m);
      wr_preg(4'd2, TBL[i].s);
      issue(mk_instr(4'd1, 4'd2));
      check($sformatf("R10 table %0d nzc", i), {29'b0, flag_n_o, flag_z_o, flag_c_o},
            {29'b0, TBL[i].nzc});
      check($sformatf("R6 table %0d v", i), {31'b0, flag_v_o}, 32'd0);
      check($sformatf("R7 table %0d valid", i), {31'b0, flags_valid_o}, 32'd1);
      @(negedge clk);
      check($sformatf("R7 table %0d pulse end", i), {31'b0, flags_valid_o}, 32'd0);
    end

    // R2: extreme register indices
    run_case("R2 pg15 pn0", 4'd15, 4'd0, 32'h00F00000, 32'h00100000);
    run_case("R2 pg0 pn15", 4'd0, 4'd15, 32'h00000001, 32'hFFFFFFFE);

    // R4/R5: single active element at each end
    run_case("R4 single low", 4'd4, 4'd5, 32'h00000001, 32'h00000001);
    run_case("R5 single high", 4'd4, 4'd5, 32'h80000000, 32'h7FFFFFFF);
    run_case("R3 zero mask", 4'd6, 4'd9, 32'h00000000, 32'hA5A5A5A5);

    // random
    for (int k = 0; k < 60; k++) begin
      logic [PL-1:0] m, s;
      m = (k % 3 == 0) ? ($urandom & $urandom & $urandom) : $urandom;
      s = $urandom;
      run_case("R3 random", 4'($urandom), 4'($urandom), m, s);
    end

    // R8: setup a known flag state, then mismatch
    run_case("R8 setup", 4'd1, 4'd2, 32'hFFFFFFFF, 32'hFFFFFFFF); // nzc=100
    snap = {flag_n_o, flag_z_o, flag_c_o, flag_v_o};
    wr_preg(4'd1, 32'h0); // would give 011 if executed
    issue(mk_instr(4'd1, 4'd2) | 32'h0000_0200); // bit 9 set
    check("R8 bad bit9 undef", {30'b0, undef_o, flags_valid_o}, 32'b10);
    check("R8 bad bit9 hold", {28'b0, flag_n_o, flag_z_o, flag_c_o, flag_v_o}, {28'b0, snap});
    issue(mk_instr(4'd1, 4'd2) ^ 32'h8000_0000);
    check("R8 bad opcode undef", {30'b0, undef_o, flags_valid_o}, 32'b10);
    check("R8 bad opcode hold", {28'b0, flag_n_o, flag_z_o, flag_c_o, flag_v_o}, {28'b0, snap});
    @(negedge clk);
    check("R8 undef pulse end", {31'b0, undef_o}, 32'd0);
    en_i = 1'b0;
    issue(mk_instr(4'd1, 4'd2));
    check("R8 disabled undef", {30'b0, undef_o, flags_valid_o}, 32'b10);
    check("R8 disabled hold", {28'b0, flag_n_o, flag_z_o, flag_c_o, flag_v_o}, {28'b0, snap});
    en_i = 1'b1;
    issue(mk_instr(4'd1, 4'd2));
    check("R10 later write seen", {29'b0, flag_n_o, flag_z_o, flag_c_o}, 32'b011);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule